// File: doc/BRIEF.md
# Split Associative Row Buffer Controller

This block keeps the row-buffer bookkeeping for one bank of a multi-level-cell memory. Each cell stores a fast-read bit and a fast-write bit. The bank's 8 KB of sense/latch storage is treated as two 4 KB buffers, numbered 0 and 1. The block does not hold any data. It holds a tag per buffer (row address and half), a valid bit, a dirty bit and a least-recently-used pointer. For each request it returns hit or miss, the buffer index that drives the data multiplexer, and the writeback and fill commands the bank sequencer must perform.

The block has two modes, chosen by a mode input that is changed only while reset is held.

- **Coupled mode:** the two buffers act as one 8 KB row. Buffer 0 always carries the fast-read half and buffer 1 the fast-write half of the same row. A miss therefore reloads both buffers.
- **Split mode:** each buffer is tagged on its own and may hold either half of any row. This lets the fast-read half of one row and the fast-write half of another row stay open at the same time.

When a dirty buffer must be replaced, the writeback is issued one cycle ahead of the fill. The block reports busy for that one cycle and ignores any request arriving during it.

Top module: `rbc_split_ctrl`

## Requirements
- R1: After a synchronous active-low reset all buffers are invalid and clean, and `busy`, `rsp_valid`, `wb_valid` and `fill_valid` are 0. The first request after reset is a miss.
- R2: A request accepted at a clock edge gives `rsp_valid`=1 after that edge. `rsp_hit`=1 exactly when a valid buffer's tag matches the request. A half is encoded 0 = fast-read, 1 = fast-write. A hit issues neither writeback nor fill.
- R3: In split mode, the fast-read half of one row and the fast-write half of a different row can both be open, and each gives a hit.
- R4: On a split-mode miss, an invalid buffer is filled first, with buffer 0 preferred when both are invalid. `fill_mask` has a single bit set, where bit i means buffer i. `fill_row` and `fill_half` carry the request's row and half.
- R5: On a split-mode miss with both buffers valid, the least recently used buffer is replaced. That is the buffer not named by the most recent accepted request. `rsp_sel` gives the buffer that now holds the requested half.
- R6: A write hit sets the hit buffer's dirty bit. A write miss installs the new tag as dirty. A read never clears a dirty bit.
- R7: Replacing a clean or invalid buffer raises `fill_valid` in the cycle after acceptance. Replacing a dirty buffer raises `wb_valid` in that cycle instead, carrying the old row, the old half (0 in coupled mode) and `wb_mask`. `busy` is high in the same cycle, and `fill_valid` follows one cycle later.
- R8: A request presented while `busy` is 1 is ignored. It produces no response and changes no tag, dirty or LRU state.
- R9: In coupled mode, a request for either half of the open row hits, and `rsp_sel` equals the requested half.
- R10: A coupled-mode miss fills with `fill_mask`=2'b11 and `fill_half`=0. The write-back mask lists the dirty halves of the old row, and only the half written becomes dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| split_mode | input | 1 | 1 = two independent buffers, 0 = one coupled row; changed only in reset |
| req_valid | input | 1 | Request present |
| req_row | input | ROW_W | Row address of the request |
| req_half | input | 1 | 0 = fast-read half, 1 = fast-write half |
| req_write | input | 1 | 1 = write access |
| busy | output | 1 | Writeback cycle in progress; requests ignored |
| rsp_valid | output | 1 | Response for the request accepted at the previous edge |
| rsp_hit | output | 1 | Response was a hit |
| rsp_sel | output | 1 | Buffer index for the output multiplexer |
| wb_valid | output | 1 | Writeback command |
| wb_mask | output | 2 | Buffers to write back |
| wb_row | output | ROW_W | Row being written back |
| wb_half | output | 1 | Half being written back (split mode) |
| fill_valid | output | 1 | Fill command |
| fill_mask | output | 2 | Buffers to fill |
| fill_row | output | ROW_W | Row being filled |
| fill_half | output | 1 | Half being filled (split mode) |

## Verification
A wrong tag, valid, dirty or LRU bit stays hidden until a later request touches the affected buffer. It then shows up as a wrong hit flag, a wrong select, a missing or spurious writeback, or a fill aimed at the wrong buffer. With only two buffers and a row range of four values in random traffic, any such divergence surfaces within a few requests. Comparing every output against the bench model on every clock localises the fault to the request that exposed it.

// File: rtl/rbc_pkg.sv
// Shared definitions for the split row buffer controller.
// Assumes exactly two buffers, each holding half of one row.
package rbc_pkg;
    localparam int NUM_BUF = 2;
    localparam int BUF_IDX_W = 1;

    typedef enum logic {
        HALF_FAST_RD = 1'b0,
        HALF_FAST_WR = 1'b1
    } half_e;
endpackage

// File: rtl/rbc_way.sv
// One buffer's tag slot: valid, row, half and dirty bit.
// Compares its tag with the incoming key and reports a match.
// Assumes load and mark_dirty are never both asserted in one cycle.
module rbc_way #(
    parameter int ROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] key_row,
    input  logic             key_half,
    input  logic             load,
    input  logic [ROW_W-1:0] load_row,
    input  logic             load_half,
    input  logic             load_dirty,
    input  logic             mark_dirty,
    output logic             vld,
    output logic [ROW_W-1:0] row,
    output logic             half,
    output logic             dirty,
    output logic             match
);
    // Tag slot update: reset clears, load installs, a write hit marks dirty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld   <= 1'b0;
            row   <= '0;
            half  <= 1'b0;
            dirty <= 1'b0;
        end else if (load) begin
            vld   <= 1'b1;
            row   <= load_row;
            half  <= load_half;
            dirty <= load_dirty;
        end else if (mark_dirty) begin
            dirty <= 1'b1;
        end
    end

    // Tag comparison against the request.
    always_comb match = vld && (row == key_row) && (half == key_half);
endmodule

// File: rtl/rbc_victim.sv
// Chooses the buffer to refill on a miss.
// Split mode: first invalid buffer (0 before 1), else the LRU buffer.
// Coupled mode: the buffer carrying the requested half.
module rbc_victim (
    input  logic       split_mode,
    input  logic [1:0] vld,
    input  logic       lru,
    input  logic       req_half,
    output logic       victim
);
    // Victim priority selection.
    always_comb begin
        if (!split_mode)  victim = req_half;
        else if (!vld[0]) victim = 1'b0;
        else if (!vld[1]) victim = 1'b1;
        else              victim = lru;
    end
endmodule

// File: rtl/rbc_split_ctrl.sv
// Row buffer controller for one bank, coupled or split operation.
// Tracks two tagged half-row buffers, decides hit/miss, picks victims,
// keeps dirty and LRU state, and issues writeback-then-fill commands.
// Assumes split_mode changes only while rst_n is low.
module rbc_split_ctrl
    import rbc_pkg::*;
#(
    parameter int ROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             split_mode,
    input  logic             req_valid,
    input  logic [ROW_W-1:0] req_row,
    input  logic             req_half,
    input  logic             req_write,
    output logic             busy,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_sel,
    output logic             wb_valid,
    output logic [1:0]       wb_mask,
    output logic [ROW_W-1:0] wb_row,
    output logic             wb_half,
    output logic             fill_valid,
    output logic [1:0]       fill_mask,
    output logic [ROW_W-1:0] fill_row,
    output logic             fill_half
);
    logic [NUM_BUF-1:0] w_vld, w_half, w_dirty, w_match;
    logic [NUM_BUF-1:0] w_load, w_ldirty, w_mark, w_lhalf, w_wb;
    logic [ROW_W-1:0]   w_row [NUM_BUF];
    logic               lru, victim, accept, any_hit, sel, miss, need_wb;

    always_comb accept  = req_valid && !busy;
    always_comb any_hit = |w_match;
    always_comb miss    = accept && !any_hit;
    always_comb sel     = any_hit ? w_match[1] : victim;
    always_comb need_wb = |w_wb;

    rbc_victim u_victim (
        .split_mode (split_mode),
        .vld        (w_vld),
        .lru        (lru),
        .req_half   (req_half),
        .victim     (victim)
    );

    for (genvar i = 0; i < NUM_BUF; i++) begin : g_way
        // Per-buffer load, dirty and writeback decisions.
        always_comb begin
            w_load[i]   = miss && (!split_mode || (victim == BUF_IDX_W'(i)));
            w_lhalf[i]  = split_mode ? req_half : 1'(i);
            w_ldirty[i] = req_write && (split_mode || (req_half == 1'(i)));
            w_mark[i]   = accept && w_match[i] && req_write;
            w_wb[i]     = w_load[i] && w_vld[i] && w_dirty[i];
        end

        rbc_way #(.ROW_W(ROW_W)) u_way (
            .clk        (clk),
            .rst_n      (rst_n),
            .key_row    (req_row),
            .key_half   (req_half),
            .load       (w_load[i]),
            .load_row   (req_row),
            .load_half  (w_lhalf[i]),
            .load_dirty (w_ldirty[i]),
            .mark_dirty (w_mark[i]),
            .vld        (w_vld[i]),
            .row        (w_row[i]),
            .half       (w_half[i]),
            .dirty      (w_dirty[i]),
            .match      (w_match[i])
        );
    end

    // LRU pointer: in split mode, names the buffer not just used.
    always_ff @(posedge clk) begin
        if (!rst_n)                   lru <= 1'b0;
        else if (accept && split_mode) lru <= ~sel;
    end

    // Response and writeback/busy registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_sel   <= 1'b0;
            busy      <= 1'b0;
            wb_valid  <= 1'b0;
            wb_mask   <= '0;
            wb_row    <= '0;
            wb_half   <= 1'b0;
        end else begin
            rsp_valid <= accept;
            busy      <= miss && need_wb;
            wb_valid  <= miss && need_wb;
            if (accept) begin
                rsp_hit <= any_hit;
                rsp_sel <= sel;
            end
            if (miss) begin
                wb_mask <= w_wb;
                wb_row  <= split_mode ? w_row[victim] : w_row[0];
                wb_half <= split_mode ? w_half[victim] : 1'b0;
            end
        end
    end

    // Fill command: immediate on a clean miss, one cycle late after a writeback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_valid <= 1'b0;
            fill_mask  <= '0;
            fill_row   <= '0;
            fill_half  <= 1'b0;
        end else begin
            fill_valid <= (miss && !need_wb) || busy;
            if (miss) begin
                fill_mask <= w_load;
                fill_row  <= req_row;
                fill_half <= split_mode ? req_half : 1'b0;
            end
        end
    end
endmodule

// File: rtl/rbc_split_ctrl_chk.sv
// Temporal checks on the row buffer controller's ports.
// Assumes split_mode is only changed while reset is asserted.
module rbc_split_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       split_mode,
    input logic       busy,
    input logic       rsp_valid,
    input logic       rsp_hit,
    input logic       wb_valid,
    input logic       fill_valid,
    input logic [1:0] fill_mask
);
    // R7
    wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> fill_valid);
    // R7
    busy_with_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> wb_valid);
    // R8
    busy_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rsp_valid);
    // R2
    hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (!wb_valid && !fill_valid));
    // R2
    miss_acts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (wb_valid || fill_valid));
    // R4
    split_fill_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && split_mode) |-> ($countones(fill_mask) == 1));
    // R10
    coupled_fill_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !split_mode) |-> (fill_mask == 2'b11));
    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(split_mode));
endmodule

bind rbc_split_ctrl rbc_split_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .split_mode (split_mode),
    .busy       (busy),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .wb_valid   (wb_valid),
    .fill_valid (fill_valid),
    .fill_mask  (fill_mask)
);

// File: tb/tb_rbc_split_ctrl.sv
// Bench: behavioural reference model compared against the DUT every clock.
module tb_rbc_split_ctrl;
    localparam int ROW_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic split_mode = 1'b1;
    logic req_valid = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic req_half = 1'b0;
    logic req_write = 1'b0;
    logic busy, rsp_valid, rsp_hit, rsp_sel, wb_valid, wb_half, fill_valid, fill_half;
    logic [1:0] wb_mask, fill_mask;
    logic [ROW_W-1:0] wb_row, fill_row;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rbc_split_ctrl #(.ROW_W(ROW_W)) dut (
        .clk(clk), .rst_n(rst_n), .split_mode(split_mode),
        .req_valid(req_valid), .req_row(req_row), .req_half(req_half),
        .req_write(req_write), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_sel(rsp_sel), .wb_valid(wb_valid),
        .wb_mask(wb_mask), .wb_row(wb_row), .wb_half(wb_half),
        .fill_valid(fill_valid), .fill_mask(fill_mask),
        .fill_row(fill_row), .fill_half(fill_half)
    );

    // Reference model state
    bit        m_v [2];
    int        m_row [2];
    bit        m_half [2];
    bit        m_d [2];
    int        m_lru;
    bit        e_busy, e_rsp, e_hit, e_wb, e_fill;
    int        e_sel, e_wb_mask, e_wb_row, e_wb_half;
    int        e_fill_mask, e_fill_row, e_fill_half;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_v[i] = 0; m_d[i] = 0; m_row[i] = 0; m_half[i] = 0;
            end
            m_lru = 0;
            e_busy = 0; e_rsp = 0; e_wb = 0; e_fill = 0;
        end else begin
            e_rsp = 0; e_wb = 0; e_fill = 0;
            if (e_busy) begin
                e_busy = 0;
                e_fill = 1;
            end else if (req_valid) begin
                int hit;
                hit = -1;
                e_rsp = 1;
                if (split_mode) begin
                    for (int i = 0; i < 2; i++)
                        if (m_v[i] && m_row[i] == int'(req_row) && m_half[i] == req_half) hit = i;
                end else if (m_v[0] && m_row[0] == int'(req_row)) begin
                    hit = int'(req_half);
                end
                if (hit >= 0) begin
                    e_hit = 1;
                    e_sel = hit;
                    if (req_write) m_d[hit] = 1;
                    if (split_mode) m_lru = 1 - hit;
                end else begin
                    e_hit = 0;
                    if (split_mode) begin
                        int v;
                        v = !m_v[0] ? 0 : (!m_v[1] ? 1 : m_lru);
                        e_sel = v;
                        m_lru = 1 - v;
                        if (m_v[v] && m_d[v]) begin
                            e_wb = 1; e_busy = 1;
                            e_wb_mask = 1 << v; e_wb_row = m_row[v]; e_wb_half = int'(m_half[v]);
                        end else e_fill = 1;
                        e_fill_mask = 1 << v; e_fill_row = int'(req_row); e_fill_half = int'(req_half);
                        m_v[v] = 1; m_row[v] = int'(req_row); m_half[v] = req_half; m_d[v] = req_write;
                    end else begin
                        int msk;
                        e_sel = int'(req_half);
                        msk = 0;
                        for (int i = 0; i < 2; i++) if (m_v[i] && m_d[i]) msk |= (1 << i);
                        if (msk != 0) begin
                            e_wb = 1; e_busy = 1;
                            e_wb_mask = msk; e_wb_row = m_row[0]; e_wb_half = 0;
                        end else e_fill = 1;
                        e_fill_mask = 3; e_fill_row = int'(req_row); e_fill_half = 0;
                        for (int i = 0; i < 2; i++) begin
                            m_v[i] = 1; m_row[i] = int'(req_row); m_half[i] = 1'(i);
                            m_d[i] = req_write && (int'(req_half) == i);
                        end
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-clock comparison, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(busy == e_busy, "R7", "busy", int'(busy), int'(e_busy));
            chk(rsp_valid == e_rsp, "R8", "rsp_valid", int'(rsp_valid), int'(e_rsp));
            if (e_rsp) begin
                chk(rsp_hit == e_hit, "R2", "rsp_hit", int'(rsp_hit), int'(e_hit));
                chk(int'(rsp_sel) == e_sel, split_mode ? "R5" : "R9", "rsp_sel", int'(rsp_sel), e_sel);
            end
            chk(wb_valid == e_wb, "R7", "wb_valid", int'(wb_valid), int'(e_wb));
            if (e_wb) begin
                chk(int'(wb_mask) == e_wb_mask, split_mode ? "R7" : "R10", "wb_mask", int'(wb_mask), e_wb_mask);
                chk(int'(wb_row) == e_wb_row, "R7", "wb_row", int'(wb_row), e_wb_row);
                chk(int'(wb_half) == e_wb_half, "R7", "wb_half", int'(wb_half), e_wb_half);
            end
            chk(fill_valid == e_fill, "R7", "fill_valid", int'(fill_valid), int'(e_fill));
            if (e_fill) begin
                chk(int'(fill_mask) == e_fill_mask, split_mode ? "R4" : "R10", "fill_mask", int'(fill_mask), e_fill_mask);
                chk(int'(fill_row) == e_fill_row, "R4", "fill_row", int'(fill_row), e_fill_row);
                chk(int'(fill_half) == e_fill_half, "R4", "fill_half", int'(fill_half), e_fill_half);
            end
        end
    end

    task automatic req(input int row, input bit half, input bit wr);
        req_valid = 1'b1; req_row = ROW_W'(row); req_half = half; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input bit mode);
        rst_n = 1'b0; req_valid = 1'b0;
        split_mode = mode;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk(!busy && !rsp_valid && !wb_valid && !fill_valid, "R1", "idle outputs",
            int'({busy, rsp_valid, wb_valid, fill_valid}), 0);
    endtask

    task automatic random_traffic(input int n);
        for (int i = 0; i < n; i++) begin
            req_valid = ($urandom % 4) != 0;
            req_row   = ROW_W'($urandom_range(0, 3));
            req_half  = 1'($urandom);
            req_write = ($urandom % 3) == 0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        idle(3);
    endtask

    initial begin
        @(negedge clk);
        do_reset(1'b1);
        req(5, 0, 0);            // R1 first access misses; R4 fills buffer 0
        idle(1);
        req(9, 1, 0);            // R3 other half of other row into buffer 1
        idle(1);
        req(5, 0, 0);            // R2 R3 hit in buffer 0
        req(9, 1, 1);            // R6 write hit marks buffer 1 dirty
        req(7, 0, 0);            // R5 buffer 0 is LRU and clean: plain fill
        idle(1);
        req(3, 1, 0);            // R7 LRU buffer 1 dirty: writeback then fill
        req(7, 0, 1);            // R8 presented while busy: ignored
        idle(2);
        req(7, 0, 0);            // R8 state unchanged: still a hit
        idle(2);
        random_traffic(4000);

        do_reset(1'b0);
        req(4, 1, 1);            // R10 coupled miss fills both halves, FW dirty
        idle(1);
        req(4, 0, 0);            // R9 other half of open row hits, sel 0
        req(6, 0, 0);            // R10 writeback only the dirty FW half
        idle(3);
        random_traffic(4000);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule